// File: doc/BRIEF.md
# Vector Single-Bit Clear / Set / Invert Unit

This execution unit accepts a 32-bit instruction word together with two 256-bit source vectors. It recognises a family of single-bit vector manipulations and applies the chosen one to every lane of the first source. There are three operations: clear a bit, set a bit, or flip a bit. The lane size is 8, 16, 32 or 64 bits. Each lane picks the bit it acts on in one of two ways. In the register form, the lane takes the index from the corresponding lane of the second source, reduced modulo the lane width. In the immediate form, every lane uses an unsigned immediate carried in the instruction, and the width of that immediate is tied to the lane size.

A mode input chooses between a full 256-bit operand and a 128-bit operand. In the 128-bit case only the low half is computed and the upper half of the result is forced to zero. The result and the destination register number are captured in registers, and an output strobe marks them one cycle after each accepted input. A word that matches none of the known encodings raises an illegal flag and leaves the result and destination untouched. The register file and hazard handling are outside this unit.

Top module: `vbitop_unit`

## Requirements
- R1: A clear operation returns, in each active lane, the first-source lane with the selected bit forced to 0 and every other bit unchanged.
- R2: A set operation returns, in each active lane, the first-source lane with the selected bit forced to 1 and every other bit unchanged.
- R3: An invert operation returns, in each active lane, the first-source lane with the selected bit complemented and every other bit unchanged.
- R4: In the register form, the bit index of each lane is the same lane of the second source modulo the lane width. Only its low 3, 4, 5 or 6 bits count, for 8, 16, 32 or 64-bit lanes, so an index equal to or above the lane width wraps around.
- R5: In the immediate form, one unsigned index applies to all lanes. It is taken from instr[12:10] for byte lanes, instr[13:10] for 16-bit, instr[14:10] for 32-bit and instr[15:10] for 64-bit lanes.
- R6: Register-form encodings: instr[31:20]=0x750 with instr[19:15]=11000..11011 means clear on 8/16/32/64-bit lanes and 11100..11111 means set. instr[31:20]=0x751 with instr[19:15]=00000..00011 means invert. The index source field is instr[14:10].
- R7: Immediate-form encodings have instr[31:20]=0x771. instr[19:18] is 00 for clear, 01 for set and 10 for invert. The size is read from instr[17:13]: 00001 is 8-bit, 0001x is 16-bit, 001xx is 32-bit and 01xxx is 64-bit.
- R8: With wide_mode=1, all 256 bits are processed. With wide_mode=0, only bits [127:0] are processed and result[255:128] is 0.
- R9: Each input taken with in_valid=1 produces an out_valid pulse in the following cycle. For a legal word, result and dest_idx (instr[4:0]) are updated at that same edge.
- R10: A valid word that matches none of the R6/R7 encodings sets illegal=1 in the next cycle, and result and dest_idx keep their previous values. A following legal word clears illegal.
- R11: After reset, out_valid, illegal, dest_idx and result are all 0.
- R12: While in_valid is 0, out_valid stays 0 one cycle later, and result and dest_idx do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operands are present this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | 256 | Vector whose lanes are modified |
| src_b | input | 256 | Vector supplying per-lane bit indices (register form) |
| wide_mode | input | 1 | 1: 256-bit operand, 0: 128-bit operand |
| out_valid | output | 1 | Registered strobe, one cycle after in_valid |
| result | output | 256 | Registered result vector |
| dest_idx | output | 5 | Registered destination register number |
| illegal | output | 1 | Last valid word matched no encoding |

## Verification
On every cycle, the assertions check the handshake timing of R9 and R12, the zero upper half in narrow mode (R8), that result is held after an illegal word (R10), and that dest_idx follows the previous instruction's low field. Bit-exact lane results cannot be written as a short property. Those need the bench's reference model, run over all 24 legal encodings with random operands, with indices at and above the lane width, and with malformed words near the legal patterns. Those scenarios are what establish R1 to R7.

// File: rtl/vbit_pkg.sv
package vbit_pkg;

    typedef enum logic [1:0] {
        BOP_CLR = 2'd0,
        BOP_SET = 2'd1,
        BOP_INV = 2'd2
    } bitop_e;

    typedef enum logic [1:0] {
        LSZ_8  = 2'd0,
        LSZ_16 = 2'd1,
        LSZ_32 = 2'd2,
        LSZ_64 = 2'd3
    } lane_sz_e;

    typedef struct packed {
        logic     legal;
        bitop_e   op;
        lane_sz_e size;
        logic     use_imm;
        logic [5:0] imm;
        logic [4:0] rd;
    } vbit_dec_t;

    localparam logic [11:0] GRP_REG_CS  = 12'h750;
    localparam logic [11:0] GRP_REG_INV = 12'h751;
    localparam logic [11:0] GRP_IMM     = 12'h771;

endpackage

// File: rtl/vbit_lane_array.sv
module vbit_lane_array
    import vbit_pkg::*;
#(
    parameter int VEC_W  = 256,
    parameter int LANE_W = 8
) (
    input  bitop_e             op,
    input  logic               use_imm,
    input  logic [5:0]         imm,
    input  logic [VEC_W-1:0]   a,
    input  logic [VEC_W-1:0]   b,
    output logic [VEC_W-1:0]   y
);
    localparam int NLANES = VEC_W / LANE_W;
    localparam logic [LANE_W-1:0] ONE      = LANE_W'(1);
    localparam logic [LANE_W-1:0] IDX_MASK = LANE_W'(LANE_W - 1);

    for (genvar l = 0; l < NLANES; l++) begin : g_lane
        logic [LANE_W-1:0] a_l;
        logic [LANE_W-1:0] b_l;
        logic [LANE_W-1:0] sh;
        logic [LANE_W-1:0] bitmask;

        assign a_l = a[l*LANE_W +: LANE_W];
        assign b_l = b[l*LANE_W +: LANE_W];

        always_comb begin
            if (use_imm) begin
                sh = LANE_W'(imm) & IDX_MASK;
            end else begin
                sh = b_l & IDX_MASK;
            end
            bitmask = ONE << sh;
            unique case (op)
                BOP_CLR: y[l*LANE_W +: LANE_W] = a_l & ~bitmask;
                BOP_SET: y[l*LANE_W +: LANE_W] = a_l | bitmask;
                default: y[l*LANE_W +: LANE_W] = a_l ^ bitmask;
            endcase
        end
    end

endmodule

// File: rtl/vbit_decode.sv
module vbit_decode
    import vbit_pkg::*;
(
    input  logic [31:0] instr,
    output vbit_dec_t   dec
);
    logic [11:0] grp;
    logic [4:0]  code;

    assign grp  = instr[31:20];
    assign code = instr[19:15];

    always_comb begin
        dec         = '0;
        dec.rd      = instr[4:0];
        dec.imm     = instr[15:10];
        dec.op      = BOP_CLR;
        dec.size    = LSZ_8;
        dec.use_imm = 1'b0;
        unique case (grp)
            GRP_REG_CS: begin
                if (code[4:3] == 2'b11) begin
                    dec.legal = 1'b1;
                    dec.op    = code[2] ? BOP_SET : BOP_CLR;
                    dec.size  = lane_sz_e'(code[1:0]);
                end
            end
            GRP_REG_INV: begin
                if (code[4:2] == 3'b000) begin
                    dec.legal = 1'b1;
                    dec.op    = BOP_INV;
                    dec.size  = lane_sz_e'(code[1:0]);
                end
            end
            GRP_IMM: begin
                dec.use_imm = 1'b1;
                if (instr[19:18] != 2'b11) begin
                    dec.op    = bitop_e'(instr[19:18]);
                    dec.legal = 1'b1;
                    casez (instr[17:13])
                        5'b00001: dec.size = LSZ_8;
                        5'b0001?: dec.size = LSZ_16;
                        5'b001??: dec.size = LSZ_32;
                        5'b01???: dec.size = LSZ_64;
                        default:  dec.legal = 1'b0;
                    endcase
                end
            end
            default: dec.legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/vbitop_unit.sv
module vbitop_unit
    import vbit_pkg::*;
#(
    parameter int VEC_W  = 256,
    parameter int BASE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [31:0]      instr,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  logic             wide_mode,
    output logic             out_valid,
    output logic [VEC_W-1:0] result,
    output logic [4:0]       dest_idx,
    output logic             illegal
);
    localparam int NSIZES   = 4;
    localparam int NARROW_W = VEC_W / 2;
    localparam logic [VEC_W-1:0] NARROW_MASK = {{(VEC_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    vbit_dec_t        dec;
    logic [VEC_W-1:0] size_res [NSIZES];
    logic [VEC_W-1:0] sel_res;
    logic [VEC_W-1:0] next_res;

    vbit_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    for (genvar s = 0; s < NSIZES; s++) begin : g_size
        vbit_lane_array #(
            .VEC_W  (VEC_W),
            .LANE_W (BASE_W << s)
        ) u_lanes (
            .op      (dec.op),
            .use_imm (dec.use_imm),
            .imm     (dec.imm),
            .a       (src_a),
            .b       (src_b),
            .y       (size_res[s])
        );
    end

    always_comb begin
        sel_res  = size_res[dec.size];
        next_res = wide_mode ? sel_res : (sel_res & NARROW_MASK);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            illegal   <= 1'b0;
            result    <= '0;
            dest_idx  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                illegal <= !dec.legal;
                if (dec.legal) begin
                    result   <= next_res;
                    dest_idx <= dec.rd;
                end
            end
        end
    end

endmodule

// File: rtl/vbit_checker.sv
module vbit_checker #(
    parameter int VEC_W = 256
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [31:0]      instr,
    input logic             wide_mode,
    input logic             out_valid,
    input logic [VEC_W-1:0] result,
    input logic [4:0]       dest_idx,
    input logic             illegal
);
    localparam int HALF = VEC_W / 2;

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r12_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(dest_idx)));

    a_r10_illegal_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && illegal) |-> ($stable(result) && $stable(dest_idx)));

    a_r9_dest_field: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !illegal) |-> (dest_idx == $past(instr[4:0])));

    a_r8_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !illegal && !$past(wide_mode)) |-> (result[VEC_W-1:HALF] == '0));

endmodule

bind vbitop_unit vbit_checker #(.VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .instr     (instr),
    .wide_mode (wide_mode),
    .out_valid (out_valid),
    .result    (result),
    .dest_idx  (dest_idx),
    .illegal   (illegal)
);

// File: tb/tb_vbitop_unit.sv
module tb_vbitop_unit;
    localparam int VW = 256;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [31:0]   instr;
    logic [VW-1:0] src_a;
    logic [VW-1:0] src_b;
    logic          wide_mode;
    logic          out_valid;
    logic [VW-1:0] result;
    logic [4:0]    dest_idx;
    logic          illegal;

    int checks = 0;
    int errors = 0;
    logic [VW-1:0] last_res;
    logic [4:0]    last_rd;

    always #4 clk = ~clk;

    vbitop_unit dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .instr     (instr),
        .src_a     (src_a),
        .src_b     (src_b),
        .wide_mode (wide_mode),
        .out_valid (out_valid),
        .result    (result),
        .dest_idx  (dest_idx),
        .illegal   (illegal)
    );

    // op: 0 clear, 1 set, 2 invert; sz: 0..3 for 8/16/32/64-bit lanes
    function automatic logic [31:0] enc(int op, int sz, bit immf, logic [4:0] rd, logic [5:0] k);
        logic [31:0] w;
        int lw;
        lw = 8 << sz;
        w = '0;
        w[4:0] = rd;
        w[9:5] = 5'd3;
        if (!immf) begin
            w[31:20] = (op == 2) ? 12'h751 : 12'h750;
            if (op == 0)      w[19:15] = 5'b11000 + 5'(sz);
            else if (op == 1) w[19:15] = 5'b11100 + 5'(sz);
            else              w[19:15] = 5'(sz);
            w[14:10] = k[4:0];
        end else begin
            w[31:20] = 12'h771;
            w[19:18] = 2'(op);
            case (sz)
                0: begin w[17:13] = 5'b00001; w[12:10] = k[2:0]; end
                1: begin w[17:14] = 4'b0001;  w[13:10] = k[3:0]; end
                2: begin w[17:15] = 3'b001;   w[14:10] = k[4:0]; end
                default: begin w[17:16] = 2'b01; w[15:10] = k[5:0]; end
            endcase
        end
        return w;
    endfunction

    function automatic logic [VW-1:0] model(int op, int sz, bit immf, logic [5:0] k,
                                            logic [VW-1:0] a, logic [VW-1:0] b, bit wide);
        logic [VW-1:0] r;
        int lw, lim;
        lw  = 8 << sz;
        lim = wide ? VW : VW / 2;
        r = '0;
        for (int p = 0; p < lim; p++) begin
            int lane, pos, idx;
            logic m;
            lane = p / lw;
            pos  = p % lw;
            idx  = 0;
            if (immf) idx = int'(k) % lw;
            else begin
                for (int q = 0; q < 6; q++)
                    if ((1 << q) < lw && b[lane*lw + q]) idx = idx | (1 << q);
            end
            m = (pos == idx);
            case (op)
                0: r[p] = a[p] & ~m;
                1: r[p] = a[p] | m;
                default: r[p] = a[p] ^ m;
            endcase
        end
        return r;
    endfunction

    function automatic logic [VW-1:0] rnd_vec();
        logic [VW-1:0] v;
        for (int i = 0; i < VW / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic chk(string tag, bit ok, logic [VW-1:0] act, logic [VW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(logic [31:0] w, logic [VW-1:0] a, logic [VW-1:0] b, bit wide);
        @(negedge clk);
        instr = w; src_a = a; src_b = b; wide_mode = wide; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_legal(int op, int sz, bit immf, logic [4:0] rd, logic [5:0] k,
                             logic [VW-1:0] a, logic [VW-1:0] b, bit wide);
        logic [VW-1:0] exp;
        string tag;
        exp = model(op, sz, immf, k, a, b, wide);
        tag = $sformatf("%s %s %s op%0d sz%0d",
                        (op == 0) ? "R1" : (op == 1) ? "R2" : "R3",
                        immf ? "R5 R7" : "R4 R6", wide ? "wide" : "R8 narrow", op, sz);
        issue(enc(op, sz, immf, rd, k), a, b, wide);
        chk({tag, " result"}, result === exp, result, exp);
        chk("R9 strobe/legal", out_valid === 1'b1 && illegal === 1'b0,
            VW'({out_valid, illegal}), VW'(2'b10));
        chk("R9 dest_idx", dest_idx === rd, VW'(dest_idx), VW'(rd));
        last_res = exp;
        last_rd  = rd;
    endtask

    task automatic run_illegal(logic [31:0] w);
        issue(w, rnd_vec(), rnd_vec(), 1'b1);
        chk($sformatf("R10 illegal flag %h", w), out_valid === 1'b1 && illegal === 1'b1,
            VW'({out_valid, illegal}), VW'(2'b11));
        chk("R10 result held", result === last_res, result, last_res);
        chk("R10 dest held", dest_idx === last_rd, VW'(dest_idx), VW'(last_rd));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [VW-1:0] a, b;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; in_valid = 1'b0; instr = '0; src_a = '0; src_b = '0; wide_mode = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset outputs", out_valid === 1'b0 && illegal === 1'b0 && dest_idx === 5'd0,
            VW'({out_valid, illegal, dest_idx}), '0);
        chk("R11 reset result", result === '0, result, '0);
        last_res = '0; last_rd = '0;

        // All 24 encodings, directed
        for (int op = 0; op < 3; op++)
            for (int sz = 0; sz < 4; sz++)
                for (int f = 0; f < 2; f++)
                    run_legal(op, sz, f[0], 5'(op*8 + sz*2 + f), 6'((8 << sz) - 1),
                              rnd_vec(), rnd_vec(), 1'b1);

        // R4: index lanes exactly at and above the lane width wrap
        for (int sz = 0; sz < 4; sz++) begin
            int lw;
            lw = 8 << sz;
            b = '0;
            for (int l = 0; l < VW / lw; l++) b[l*lw +: 8] = 8'(lw + (l % 3) * lw + (l % 5));
            run_legal(2, sz, 1'b0, 5'd17, 6'd0, '1, b, 1'b1);
            run_legal(0, sz, 1'b0, 5'd18, 6'd0, '1, b, 1'b0);
        end

        // R10: malformed words near the legal patterns
        run_illegal(32'h0000_0000);
        run_illegal({12'h751, 5'b00100, 15'h0});
        run_illegal({12'h750, 5'b10111, 15'h0});
        run_illegal({12'h771, 5'b00000, 15'h0});
        run_illegal({12'h771, 2'b11, 3'b001, 15'h0});
        run_legal(1, 2, 1'b1, 5'd9, 6'd31, rnd_vec(), rnd_vec(), 1'b1);
        chk("R10 illegal cleared", illegal === 1'b0, VW'(illegal), '0);

        // R12: idle cycles leave outputs alone
        repeat (5) @(negedge clk);
        chk("R12 no strobe when idle", out_valid === 1'b0, VW'(out_valid), '0);
        chk("R12 result stable when idle", result === last_res, result, last_res);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int op, sz;
            bit f, wide;
            op = $urandom_range(2);
            sz = $urandom_range(3);
            f = 1'($urandom);
            wide = 1'($urandom);
            a = rnd_vec();
            b = rnd_vec();
            if (i % 7 == 0) a = '0;
            if (i % 11 == 0) a = '1;
            run_legal(op, sz, f, 5'($urandom), 6'($urandom) & 6'((8 << sz) - 1), a, b, wide);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule